// File: doc/BRIEF.md
# Dead-Time Complementary Pair Generator

This block sits between a PWM waveform source and the gate drivers of one bridge leg. It takes two raw PWM waveforms and turns them into a high-side/low-side drive pair. When enabled, it builds both gate signals from the first waveform alone. The high-side output follows the waveform, but its turn-on is held back by a programmable number of clock cycles. The low-side output follows the inverse of the waveform, and its turn-on is held back by a second, independent count. Neither switch can therefore turn on until its partner has been off for the programmed time. A pulse shorter than the hold-off never reaches the output.

When disabled, both raw waveforms reach the outputs untouched apart from one register stage. That same register latency applies in enabled mode, so switching modes does not shift the time base. Each hold-off count is captured when its interval begins. Software may therefore rewrite the counts at any time without distorting a pulse that is already being timed.

Top module: `deadtime_pair`

## Requirements
- R1: While `rst_n` is low, both outputs are 0 from the first clock edge on.
- R2: With `en` low in cycle t-1, `out_a` and `out_b` in cycle t equal `pwm_a` and `pwm_b` sampled in cycle t-1.
- R3: With `en` high, the value of `pwm_b` has no effect on either output.
- R4: With `en` high, `out_a` is 1 in cycle t only if `pwm_a` was 1 in each of the `rise_dly`+1 samples ending at cycle t-1, all of them since reset.
- R5: With `en` high, `out_b` is 1 in cycle t only if `pwm_a` was 0 in each of the `fall_dly`+1 samples ending at cycle t-1, all of them since reset.
- R6: A hold-off count of 0 adds no dead time: `out_a` is the previous sample of `pwm_a`, and `out_b` is its inverse.
- R7: A high or low stretch of `pwm_a` no longer than the matching hold-off count gives no pulse at the matching output.
- R8: Whenever `en` was high in the previous cycle, `out_a` and `out_b` are never both 1.
- R9: Each hold-off count is captured in the first sample of its interval. A later change to `rise_dly` or `fall_dly` does not alter the interval already running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | 1: dead-time mode, 0: pass-through |
| pwm_a | input | 1 | Raw waveform A; in dead-time mode, the source of both outputs |
| pwm_b | input | 1 | Raw waveform B; used only in pass-through |
| rise_dly | input | DLY_W | Hold-off in cycles before `out_a` may rise |
| fall_dly | input | DLY_W | Hold-off in cycles before `out_b` may rise after `pwm_a` falls |
| out_a | output | 1 | High-side drive |
| out_b | output | 1 | Low-side drive |

## Verification
The bench builds the block with its default 12-bit count width and drives only small hold-off values: 0, 1, 2, 3 and 5. With these values, the start-of-interval capture, the saturation of the run counter and the suppression of short pulses all occur within a few cycles. Every boundary therefore gets exercised in a short run. One count is rewritten in the middle of an interval, which shows that the captured value governs. The raw B waveform is toggled in dead-time mode to show that it is discarded.

// File: rtl/deadtime_pkg.sv
// Shared constants for the dead-time pair generator.
package deadtime_pkg;
    localparam int unsigned DLY_W_DEFAULT = 12;
    localparam int unsigned NUM_LANES     = 2;

    // Lane index: lane A times the high side, lane B times the low side.
    typedef enum logic {
        LANE_A = 1'b0,
        LANE_B = 1'b1
    } lane_e;
endpackage

// File: rtl/dt_rise_hold.sv
// Holds back the rising edge of one signal by a captured cycle count.
// The output is registered. It is 1 only once the input has been high for
// (captured count + 1) consecutive samples. The count is captured on the
// first high sample of each run. The run counter saturates at the captured
// count, so it never wraps.
// Assumes: sig_in is synchronous to clk.
module dt_rise_hold #(
    parameter int unsigned DLY_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_in,
    input  logic [DLY_W-1:0] dly,
    output logic             sig_out
);
    localparam logic [DLY_W-1:0] ONE = {{(DLY_W-1){1'b0}}, 1'b1};

    logic [DLY_W-1:0] run_q;
    logic [DLY_W-1:0] dly_q;

    // Count the high run, capture the count at its start, release the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= '0;
            dly_q   <= '0;
            sig_out <= 1'b0;
        end else if (!sig_in) begin
            run_q   <= '0;
            sig_out <= 1'b0;
        end else if (run_q == '0) begin
            dly_q   <= dly;
            run_q   <= ONE;
            sig_out <= (dly == '0);
        end else begin
            sig_out <= (run_q >= dly_q);
            if (run_q < dly_q) begin
                run_q <= run_q + ONE;
            end
        end
    end
endmodule

// File: rtl/dt_out_sel.sv
// Picks between the raw pair and the dead-time pair. The raw pair and the
// mode bit are registered here, so both paths have one cycle of latency.
// Assumes: gated_a/gated_b already come from registers (one cycle after
// their source sample).
module dt_out_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic raw_a,
    input  logic raw_b,
    input  logic gated_a,
    input  logic gated_b,
    output logic out_a,
    output logic out_b
);
    logic en_q;
    logic raw_a_q;
    logic raw_b_q;

    // Register the mode and the raw pair to match the hold stage latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            raw_a_q <= 1'b0;
            raw_b_q <= 1'b0;
        end else begin
            en_q    <= en;
            raw_a_q <= raw_a;
            raw_b_q <= raw_b;
        end
    end

    // Select the output pair from registered sources only.
    always_comb begin
        out_a = en_q ? gated_a : raw_a_q;
        out_b = en_q ? gated_b : raw_b_q;
    end
endmodule

// File: rtl/deadtime_pair.sv
// Dead-time pair generator top. Lane A holds back the rise of pwm_a, and
// lane B holds back the rise of the inverted pwm_a. The two lane inputs are
// never high together, so the lane outputs cannot overlap. The output
// selector chooses that pair or the raw pwm_a/pwm_b pair.
// Assumes: all inputs are synchronous to clk.
module deadtime_pair
    import deadtime_pkg::*;
#(
    parameter int unsigned DLY_W = DLY_W_DEFAULT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             pwm_a,
    input  logic             pwm_b,
    input  logic [DLY_W-1:0] rise_dly,
    input  logic [DLY_W-1:0] fall_dly,
    output logic             out_a,
    output logic             out_b
);
    logic [NUM_LANES-1:0] lane_in;
    logic [NUM_LANES-1:0] lane_out;
    logic [DLY_W-1:0]     lane_dly [NUM_LANES];

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        if (i == int'(LANE_A)) begin : g_high
            assign lane_in[i]  = pwm_a;
            assign lane_dly[i] = rise_dly;
        end else begin : g_low
            assign lane_in[i]  = ~pwm_a;
            assign lane_dly[i] = fall_dly;
        end

        dt_rise_hold #(.DLY_W(DLY_W)) u_hold (
            .clk     (clk),
            .rst_n   (rst_n),
            .sig_in  (lane_in[i]),
            .dly     (lane_dly[i]),
            .sig_out (lane_out[i])
        );
    end

    dt_out_sel u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .raw_a   (pwm_a),
        .raw_b   (pwm_b),
        .gated_a (lane_out[int'(LANE_A)]),
        .gated_b (lane_out[int'(LANE_B)]),
        .out_a   (out_a),
        .out_b   (out_b)
    );
endmodule

// File: rtl/deadtime_pair_chk.sv
// Port-level properties of the dead-time pair generator, bound to the top.
module deadtime_pair_chk #(
    parameter int unsigned DLY_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             pwm_a,
    input logic             pwm_b,
    input logic [DLY_W-1:0] rise_dly,
    input logic [DLY_W-1:0] fall_dly,
    input logic             out_a,
    input logic             out_b
);
    // R2: pass-through follows the previous raw samples.
    a_r2_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(en)) |-> (out_a == $past(pwm_a) && out_b == $past(pwm_b)));

    // R4: a low sample of pwm_a keeps the high side off.
    a_r4_low_blocks_a: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en) && !$past(pwm_a)) |-> !out_a);

    // R5: a high sample of pwm_a keeps the low side off.
    a_r5_high_blocks_b: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en) && $past(pwm_a)) |-> !out_b);

    // R6: with a zero hold-off, a fresh rise of pwm_a shows at once.
    a_r6_zero_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en) && $past(pwm_a) && !$past(pwm_a, 2)
         && ($past(rise_dly) == '0)) |-> out_a);

    // R8: no overlap of the pair in dead-time mode.
    a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en)) |-> !(out_a && out_b));
endmodule

bind deadtime_pair deadtime_pair_chk #(.DLY_W(DLY_W)) u_chk (.*);

// File: tb/deadtime_pair_tb.sv
// Bench: vector table walk, then directed reset and corner tests.
module deadtime_pair_tb;
    localparam int DW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          pwm_a = 1'b1;
    logic          pwm_b = 1'b1;
    logic [DW-1:0] rise_dly = '0;
    logic [DW-1:0] fall_dly = '0;
    logic          out_a;
    logic          out_b;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    deadtime_pair #(.DLY_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .pwm_a(pwm_a), .pwm_b(pwm_b),
        .rise_dly(rise_dly), .fall_dly(fall_dly), .out_a(out_a), .out_b(out_b)
    );

    // Row bits: {en, pwm_a, pwm_b, expected out_a, expected out_b}.
    // Rows 0-15 and 20 use rise 2 and fall 1. Rows 8-11 carry the short pulses.
    localparam logic [4:0] VEC [21] = '{
        5'b10100, 5'b10001, 5'b11100, 5'b11000, 5'b11110, 5'b11010,
        5'b10000, 5'b10101, 5'b11000, 5'b11100, 5'b10000, 5'b11100,
        5'b11000, 5'b11110, 5'b10100, 5'b10101, 5'b01010, 5'b01111,
        5'b00101, 5'b00000, 5'b10101
    };

    task automatic check(input string req, input logic [1:0] exp_ab);
        n_chk++;
        if ({out_a, out_b} !== exp_ab) begin
            n_bad++;
            $display("FAIL %s: actual a/b=%b expected a/b=%b", req, {out_a, out_b}, exp_ab);
        end
    endtask

    // Drive at a falling edge, then wait for the next falling edge.
    task automatic step(input logic e, input logic a, input logic b);
        en = e; pwm_a = a; pwm_b = b;
        @(negedge clk);
    endtask

    initial begin
        // R1: reset holds both outputs low, even with raw inputs high.
        @(negedge clk);
        check("R1 reset", 2'b00);
        @(negedge clk);
        check("R1 reset", 2'b00);

        rise_dly = 12'd2; fall_dly = 12'd1; rst_n = 1'b1;
        for (int i = 0; i < 21; i++) begin
            step(VEC[i][4], VEC[i][3], VEC[i][2]);
            check($sformatf("R2/R3/R4/R5/R7/R8 row %0d", i), VEC[i][1:0]);
        end

        // R6: zero hold-off gives a direct complementary copy.
        rise_dly = '0; fall_dly = '0;
        begin
            logic [5:0] pat = 6'b110100;
            for (int k = 5; k >= 0; k--) begin
                step(1'b1, pat[k], 1'b1);
                check("R6 zero dead time", {pat[k], ~pat[k]});
            end
        end

        // R9: the count is captured at the start of the run; a later rewrite is ignored.
        rise_dly = 12'd3;
        step(1'b1, 1'b1, 1'b0);
        check("R9 captured count", 2'b00);
        rise_dly = '0;
        step(1'b1, 1'b1, 1'b1);
        check("R9 captured count", 2'b00);
        step(1'b1, 1'b1, 1'b0);
        check("R9 captured count", 2'b00);
        step(1'b1, 1'b1, 1'b1);
        check("R9 captured count", 2'b10);

        // R5 and R3: fall hold-off of 5 needs six low samples; pwm_b toggles.
        fall_dly = 12'd5;
        for (int k = 0; k < 7; k++) begin
            step(1'b1, 1'b0, k[0]);
            check("R5/R3 long fall hold-off", {1'b0, (k >= 5) ? 1'b1 : 1'b0});
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R1-R9 run: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule